// File: doc/BRIEF.md
# Block Protection State Controller

This block holds the erase and program protection state for every block of a block-organised non-volatile array. Each block has three stored bits: a lock bit, a lock-down bit and a saved lock bit. The saved bit keeps the lock value a block had before the write-protect pin forced it locked. Single-cycle commands set a lock, clear a lock or apply lock-down to one block. A write-protect input, active low, decides whether lock-down is in force. Its edges force locked-down blocks locked or restore their earlier lock value.

An erase or program request names a block. The block answers at once whether the operation may proceed. When the target is protected, it sets a sticky protect-violation flag. A query port reads back the lock bit and the lock-down bit of any block. State changes are visible on the cycle after the command or edge that caused them.

Top module: `lkctl_top`

## Requirements
- R1: After reset every block reads lock=1 and lockdown=0, and `prot_flag` is 0.
- R2: Command code 1 (set lock) makes the addressed block read lock=1 on the next cycle.
- R3: Command code 3 (set lock-down) makes the addressed block read lockdown=1 and lock=1 on the next cycle.
- R4: While `wp_n` is 0, command code 2 (clear lock) unlocks a block whose lockdown bit is 0. A block with lockdown=1 keeps its lock, lockdown and saved bits unchanged.
- R5: While `wp_n` is 1, command code 2 clears the lock bit whatever the lockdown bit is, and the lockdown bit is kept.
- R6: On a `wp_n` 1-to-0 change, every block with lockdown=1 copies its lock bit into its saved bit and reads lock=1 on the next cycle. While `wp_n` stays 0, no locked-down block is ever unlocked.
- R7: On a `wp_n` 0-to-1 change, every block with lockdown=1 takes its saved bit as its new lock bit. Blocks with lockdown=0 are unchanged.
- R8: `op_allow` is the inverse of the lock bit of the block at `op_idx`. An `op_valid` aimed at a locked block sets `prot_flag` on the next cycle. The flag then stays set. A request aimed at an unlocked block leaves the flag unchanged.
- R9: Command code 0 clears `prot_flag` on the next cycle, unless a violation occurs in the same cycle, in which case the flag is set.
- R10: A command changes only the block it addresses. A command whose index is at or above the block count changes nothing. Such an index reads lock=1 and lockdown=0, and an operation aimed at it is a violation.
- R11: A set-lock command given while `wp_n` is 0 also sets the saved bit. A locked-down block therefore stays locked when `wp_n` returns to 1.
- R12: Lockdown bits are cleared only by reset; no command or edge lowers them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wp_n | input | 1 | Write-protect level, active low |
| cmd_valid | input | 1 | Command strobe, one cycle |
| cmd_op | input | 2 | 0 clear flag, 1 set lock, 2 clear lock, 3 set lock-down |
| cmd_idx | input | IDXW | Block addressed by the command |
| op_valid | input | 1 | Erase or program request strobe |
| op_idx | input | IDXW | Block targeted by the request |
| op_allow | output | 1 | Target block is writable |
| prot_flag | output | 1 | Sticky protect-violation flag |
| qry_idx | input | IDXW | Block to read back |
| qry_lock | output | 1 | Lock bit of the queried block |
| qry_lkdn | output | 1 | Lockdown bit of the queried block |

## Verification
The checker covers the rules that hold on every cycle. A locked-down block is never unlocked while write-protect has been low. Set-lock-down and set-lock commands take effect on the next cycle. A clear under a high write-protect level unlocks its block. Violations raise the flag, and lockdown bits never fall. Two rules need a scenario to show them. The restore on a rising write-protect edge depends on what was saved earlier, and a set lock given under a low level changes the outcome of a later edge. The bench shows both with directed sequences and with a random mix checked against its own model of all three bits per block.

// File: rtl/lkctl_pkg.sv
`timescale 1ns/1ps
package lkctl_pkg;

  typedef enum logic [1:0] {
    OP_CLR_FLAG = 2'd0,
    OP_SET_LOCK = 2'd1,
    OP_CLR_LOCK = 2'd2,
    OP_SET_LKDN = 2'd3
  } cmd_op_e;

  typedef struct packed {
    logic lock;
    logic lkdn;
    logic saved;
  } blk_st_t;

  localparam blk_st_t BLK_RESET = '{lock: 1'b1, lkdn: 1'b0, saved: 1'b1};

  // Effect of a write-protect edge on one block
  function automatic blk_st_t wp_apply(blk_st_t s, logic fall, logic rise);
    blk_st_t n;
    n = s;
    if (s.lkdn && fall) begin
      n.saved = s.lock;
      n.lock  = 1'b1;
    end else if (s.lkdn && rise) begin
      n.lock = s.saved;
    end
    return n;
  endfunction

  // Effect of a command on the addressed block (applied after the edge)
  function automatic blk_st_t cmd_apply(blk_st_t s, cmd_op_e op, logic wp_lvl);
    blk_st_t n;
    n = s;
    case (op)
      OP_SET_LOCK: begin
        n.lock = 1'b1;
        if (!wp_lvl) n.saved = 1'b1;
      end
      OP_CLR_LOCK: begin
        if (wp_lvl || !s.lkdn) n.lock = 1'b0;
      end
      OP_SET_LKDN: begin
        n.lkdn  = 1'b1;
        n.lock  = 1'b1;
        n.saved = 1'b1;
      end
      default: ;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/lkctl_wp_edge.sv
`timescale 1ns/1ps
module lkctl_wp_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic wp_n,
  output logic wp_fall,
  output logic wp_rise
);
  logic wp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wp_q <= 1'b1;
    else        wp_q <= wp_n;
  end

  assign wp_fall = wp_q & ~wp_n;
  assign wp_rise = ~wp_q & wp_n;
endmodule

// File: rtl/lkctl_cell.sv
`timescale 1ns/1ps
module lkctl_cell
  import lkctl_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wp_lvl,
  input  logic    wp_fall,
  input  logic    wp_rise,
  input  logic    cmd_hit,
  input  cmd_op_e cmd_op,
  output logic    lock,
  output logic    lkdn
);
  blk_st_t st_q, st_d;

  always_comb begin
    st_d = wp_apply(st_q, wp_fall, wp_rise);
    if (cmd_hit) st_d = cmd_apply(st_d, cmd_op, wp_lvl);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= BLK_RESET;
    else        st_q <= st_d;
  end

  assign lock = st_q.lock;
  assign lkdn = st_q.lkdn;
endmodule

// File: rtl/lkctl_status.sv
`timescale 1ns/1ps
module lkctl_status (
  input  logic clk,
  input  logic rst_n,
  input  logic viol,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    flag <= 1'b0;
    else if (viol) flag <= 1'b1;
    else if (clr)  flag <= 1'b0;
  end
endmodule

// File: rtl/lkctl_top.sv
`timescale 1ns/1ps
module lkctl_top
  import lkctl_pkg::*;
#(
  parameter int NBLK = 6,
  parameter int IDXW = $clog2(NBLK)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wp_n,
  input  logic            cmd_valid,
  input  logic [1:0]      cmd_op,
  input  logic [IDXW-1:0] cmd_idx,
  input  logic            op_valid,
  input  logic [IDXW-1:0] op_idx,
  output logic            op_allow,
  output logic            prot_flag,
  input  logic [IDXW-1:0] qry_idx,
  output logic            qry_lock,
  output logic            qry_lkdn
);
  logic [NBLK-1:0] lock_vec;
  logic [NBLK-1:0] lkdn_vec;
  logic [NBLK-1:0] cmd_hit;
  logic            wp_fall, wp_rise;
  logic            op_lock;
  logic            viol, flag_clr;
  cmd_op_e         op_e;

  assign op_e = cmd_op_e'(cmd_op);

  lkctl_wp_edge u_edge (
    .clk     (clk),
    .rst_n   (rst_n),
    .wp_n    (wp_n),
    .wp_fall (wp_fall),
    .wp_rise (wp_rise)
  );

  for (genvar gi = 0; gi < NBLK; gi++) begin : g_blk
    assign cmd_hit[gi] = cmd_valid && (cmd_idx == IDXW'(gi));
    lkctl_cell u_cell (
      .clk     (clk),
      .rst_n   (rst_n),
      .wp_lvl  (wp_n),
      .wp_fall (wp_fall),
      .wp_rise (wp_rise),
      .cmd_hit (cmd_hit[gi]),
      .cmd_op  (op_e),
      .lock    (lock_vec[gi]),
      .lkdn    (lkdn_vec[gi])
    );
  end

  // Out-of-range indexes read as locked, not locked down
  always_comb begin
    op_lock  = 1'b1;
    qry_lock = 1'b1;
    qry_lkdn = 1'b0;
    for (int i = 0; i < NBLK; i++) begin
      if (op_idx == IDXW'(i)) op_lock = lock_vec[i];
      if (qry_idx == IDXW'(i)) begin
        qry_lock = lock_vec[i];
        qry_lkdn = lkdn_vec[i];
      end
    end
  end

  assign op_allow = ~op_lock;
  assign viol     = op_valid && op_lock;
  assign flag_clr = cmd_valid && (op_e == OP_CLR_FLAG);

  lkctl_status u_status (
    .clk   (clk),
    .rst_n (rst_n),
    .viol  (viol),
    .clr   (flag_clr),
    .flag  (prot_flag)
  );
endmodule

// File: rtl/lkctl_chk.sv
`timescale 1ns/1ps
module lkctl_chk #(
  parameter int NBLK = 6,
  parameter int IDXW = 3
) (
  input logic            clk,
  input logic            rst_n,
  input logic            wp_n,
  input logic            cmd_valid,
  input logic [1:0]      cmd_op,
  input logic [IDXW-1:0] cmd_idx,
  input logic            op_valid,
  input logic            op_allow,
  input logic            prot_flag,
  input logic [NBLK-1:0] lock_vec,
  input logic [NBLK-1:0] lkdn_vec
);
  localparam logic [IDXW:0] NB = (IDXW+1)'(NBLK);
  logic cmd_in;
  assign cmd_in = cmd_valid && ({1'b0, cmd_idx} < NB);

  // R3
  set_lkdn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_in && cmd_op == 2'd3) |=> (lock_vec[$past(cmd_idx)] && lkdn_vec[$past(cmd_idx)]));

  // R2
  set_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_in && cmd_op == 2'd1) |=> lock_vec[$past(cmd_idx)]);

  // R5
  clr_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_in && cmd_op == 2'd2 && wp_n) |=> !lock_vec[$past(cmd_idx)]);

  // R4
  clr_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_in && cmd_op == 2'd2 && !wp_n && lkdn_vec[cmd_idx]) |=> lock_vec[$past(cmd_idx)]);

  // R6
  wp_low_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!wp_n) |-> ((lkdn_vec & ~lock_vec) == '0));

  // R8
  viol_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && !op_allow) |=> prot_flag);

  // R12
  lkdn_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((lkdn_vec & $past(lkdn_vec)) == $past(lkdn_vec)));
endmodule

bind lkctl_top lkctl_chk #(.NBLK(NBLK), .IDXW(IDXW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wp_n      (wp_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_idx   (cmd_idx),
  .op_valid  (op_valid),
  .op_allow  (op_allow),
  .prot_flag (prot_flag),
  .lock_vec  (lock_vec),
  .lkdn_vec  (lkdn_vec)
);

// File: tb/tb_lkctl_top.sv
`timescale 1ns/1ps
module tb_lkctl_top;
  localparam int NB = 6;
  localparam int IW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          wp_n;
  logic          cmd_valid;
  logic [1:0]    cmd_op;
  logic [IW-1:0] cmd_idx;
  logic          op_valid;
  logic [IW-1:0] op_idx;
  logic          op_allow;
  logic          prot_flag;
  logic [IW-1:0] qry_idx;
  logic          qry_lock;
  logic          qry_lkdn;

  int n_chk = 0;
  int n_bad = 0;

  bit m_lock[8];
  bit m_lkdn[8];
  bit m_sav[8];
  bit m_flag;
  bit m_wp;

  always #10 clk = ~clk;

  lkctl_top #(.NBLK(NB), .IDXW(IW)) dut (
    .clk(clk), .rst_n(rst_n), .wp_n(wp_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_idx(cmd_idx),
    .op_valid(op_valid), .op_idx(op_idx), .op_allow(op_allow),
    .prot_flag(prot_flag), .qry_idx(qry_idx),
    .qry_lock(qry_lock), .qry_lkdn(qry_lkdn)
  );

  function automatic bit ref_lock(int i);
    return (i >= NB) ? 1'b1 : m_lock[i];
  endfunction

  function automatic bit ref_lkdn(int i);
    return (i >= NB) ? 1'b0 : m_lkdn[i];
  endfunction

  task automatic chk(string tag, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d at %0t", tag, what, act, exp, $time);
    end
  endtask

  // Bench model of one clock edge
  task automatic model_edge(bit wp, bit cv, bit [1:0] co, int ci, bit ov, int oi);
    bit viol;
    viol = ov && ref_lock(oi);
    for (int b = 0; b < NB; b++) begin
      if (m_lkdn[b] && m_wp && !wp) begin
        m_sav[b]  = m_lock[b];
        m_lock[b] = 1'b1;
      end else if (m_lkdn[b] && !m_wp && wp) begin
        m_lock[b] = m_sav[b];
      end
    end
    if (cv && ci < NB) begin
      if (co == 2'd1) begin
        m_lock[ci] = 1'b1;
        if (!wp) m_sav[ci] = 1'b1;
      end else if (co == 2'd2) begin
        if (wp || !m_lkdn[ci]) m_lock[ci] = 1'b0;
      end else if (co == 2'd3) begin
        m_lkdn[ci] = 1'b1;
        m_lock[ci] = 1'b1;
        m_sav[ci]  = 1'b1;
      end
    end
    if (viol) m_flag = 1'b1;
    else if (cv && co == 2'd0) m_flag = 1'b0;
    m_wp = wp;
  endtask

  task automatic step(string tag, bit wp, bit cv, bit [1:0] co, int ci,
                      bit ov, int oi, int qi);
    @(negedge clk);
    wp_n = wp; cmd_valid = cv; cmd_op = co; cmd_idx = IW'(ci);
    op_valid = ov; op_idx = IW'(oi); qry_idx = IW'(qi);
    #2;
    chk(tag, "op_allow", int'(op_allow), int'(!ref_lock(oi)));
    @(posedge clk);
    model_edge(wp, cv, co, ci, ov, oi);
    #2;
    chk(tag, "qry_lock", int'(qry_lock), int'(ref_lock(qi)));
    chk(tag, "qry_lkdn", int'(qry_lkdn), int'(ref_lkdn(qi)));
    chk(tag, "prot_flag", int'(prot_flag), int'(m_flag));
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual running expected finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    rst_n = 1'b0; wp_n = 1'b1; cmd_valid = 1'b0; cmd_op = 2'd0; cmd_idx = '0;
    op_valid = 1'b0; op_idx = '0; qry_idx = '0;
    for (int b = 0; b < 8; b++) begin
      m_lock[b] = 1'b1; m_lkdn[b] = 1'b0; m_sav[b] = 1'b1;
    end
    m_flag = 1'b0; m_wp = 1'b1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state of every index
    for (int q = 0; q < 8; q++) step("R1", 1, 0, 0, 0, 0, 0, q);

    // R8: request on locked block sets flag, R9: clear code drops it
    step("R8", 1, 0, 0, 0, 1, 0, 0);
    step("R8", 1, 0, 0, 0, 0, 0, 0);
    step("R9", 1, 1, 0, 0, 0, 0, 0);
    // R9: violation wins over clear in the same cycle
    step("R9", 1, 1, 0, 0, 1, 1, 0);
    step("R9", 1, 1, 0, 0, 0, 0, 0);

    // R5 then R2 on block 1
    step("R5", 1, 1, 2, 1, 0, 1, 1);
    step("R8", 1, 0, 0, 0, 1, 1, 1);
    step("R2", 1, 1, 1, 1, 0, 1, 1);

    // R3 on unlocked block 2, then R5 clears despite lockdown
    step("R3", 1, 1, 2, 2, 0, 0, 2);
    step("R3", 1, 1, 3, 2, 0, 0, 2);
    step("R5", 1, 1, 2, 2, 0, 2, 2);
    step("R3", 1, 1, 2, 3, 0, 0, 3);

    // R6: falling edge locks block 2
    step("R6", 0, 0, 0, 0, 0, 2, 2);
    // R4: held block keeps lock, free block 4 unlocks
    step("R4", 0, 1, 2, 2, 0, 2, 2);
    step("R4", 0, 1, 2, 4, 0, 4, 4);
    // R7: rising edge restores block 2 to unlocked
    step("R7", 1, 0, 0, 0, 0, 2, 2);
    step("R7", 1, 0, 0, 0, 0, 4, 4);

    // R11: set lock under low level survives the rising edge
    step("R11", 0, 0, 0, 0, 0, 2, 2);
    step("R11", 0, 1, 1, 2, 0, 2, 2);
    step("R11", 1, 0, 0, 0, 0, 2, 2);

    // R10: out-of-range index
    step("R10", 1, 1, 3, 7, 0, 7, 7);
    step("R10", 1, 1, 2, 6, 0, 6, 6);
    step("R10", 1, 1, 0, 0, 1, 6, 5);
    step("R10", 1, 1, 0, 0, 1, 3, 3);

    // R12: lockdown persists through clears and edges
    step("R12", 0, 1, 2, 2, 0, 2, 2);
    step("R12", 1, 1, 2, 2, 0, 2, 2);

    // Random mix against the model
    void'($urandom(32'd4711));
    begin
      bit wp_r;
      wp_r = 1'b1;
      for (int k = 0; k < 4000; k++) begin
        if (($urandom % 8) == 0) wp_r = ~wp_r;
        step("RAND", wp_r, ($urandom % 3) != 0, 2'($urandom % 4),
             int'($urandom % 8), ($urandom % 4) == 0,
             int'($urandom % 8), int'($urandom % 8));
      end
    end

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule